// File: doc/BRIEF.md
# Doorway Occupancy Counter

This block keeps a running count of the people inside a room that has one door. Two light-beam detectors watch the door. One sits just outside it and one just inside. A person standing in the doorway blocks both beams at once. Each detector level first passes through a synchronizer. A Mealy controller then follows the order in which the beams are blocked and cleared. When a person finishes crossing, it sends a one-cycle increment or decrement strobe to a small counter datapath.

A person may step into the doorway and then go back the way they came. This is legal and leaves the count alone. A sequence that no single person can produce is illegal. An increment that would pass the room's capacity, or a decrement below zero, is also illegal. Either case sends the controller into a locked error state and turns on the error output. The count then stays frozen until a reset.

Top module: `occ_door_counter`

## Requirements
- R1: Each detector input reads 1 while its beam is clear and 0 while it is blocked. After a synchronous active-low reset, the count is 0, the error output is 0, and both detectors are taken as clear.
- R2: An entry raises the count by one. An entry is the outside beam blocked alone, then both beams blocked, then the inside beam blocked alone, then both beams clear.
- R3: An exit lowers the count by one. An exit is the inside beam blocked alone, then both beams blocked, then the outside beam blocked alone, then both beams clear.
- R4: A person may turn back at any point and leave on the side they started from, including turning back more than once. This changes neither the count nor the error output.
- R5: If both detector inputs change between two sampled cycles, the error output is set. Examples are clear to both blocked, outside-only to inside-only, and both blocked to clear.
- R6: The error state is sticky. Any later detector activity leaves the count and the error output unchanged, and only reset clears the error.
- R7: A completed entry while the count is 15 sets the error output and leaves the count at 15. A completed exit while the count is 0 sets the error output and leaves the count at 0.
- R8: Each completed crossing changes the count by exactly one. The new count appears on the third rising clock edge after both detector inputs return to 1: two synchronizer stages, then the counter register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| beam_out_i | input | 1 | Outside detector level, 1 = beam clear |
| beam_in_i | input | 1 | Inside detector level, 1 = beam clear |
| count_o | output | 4 | People currently in the room |
| error_o | output | 1 | Sticky illegal-sequence indicator |

## Verification
The bench walks turn-backs from every doorway position, including a person who reverses twice. A controller that mistakes a partial crossing for a full one would change the count or raise the error there. It fills the room to 15 and then tries one more entry, and it tries an exit from an empty room. A design without the capacity guard would wrap the count to 0 or 15 instead of flagging an error. Each double-flip jump is tried from a fresh reset. Activity after an error confirms that the count stays frozen, since a non-sticky error state would let counting resume. One entry is sampled on the second and third edges after the final clear, which pins down the latency.

// File: rtl/occ_pkg.sv
// Package: occ_pkg
// Shared types for the doorway occupancy counter.
// Assumes the detector position code is {outside_blocked, inside_blocked}.
package occ_pkg;

    // Doorway position as seen by the controller: bit1 = outside blocked, bit0 = inside blocked
    typedef enum logic [1:0] {
        POS_CLEAR = 2'b00,
        POS_IN    = 2'b01,
        POS_OUT   = 2'b10,
        POS_BOTH  = 2'b11
    } pos_t;

    // Controller states; ENT_* follow an entering person, LVE_* a leaving one
    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_ENT_OUT  = 3'd1,
        ST_ENT_BOTH = 3'd2,
        ST_ENT_IN   = 3'd3,
        ST_LVE_IN   = 3'd4,
        ST_LVE_BOTH = 3'd5,
        ST_LVE_OUT  = 3'd6,
        ST_ERR      = 3'd7
    } state_t;

endpackage

// File: rtl/occ_sync.sv
// Module: occ_sync
// Multi-stage synchronizer for a bank of level inputs.
// Assumes: inputs are asynchronous levels and the reset value is the idle level.
module occ_sync #(
    parameter int WIDTH     = 2,
    parameter int STAGES    = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    genvar b;
    generate
        for (b = 0; b < WIDTH; b++) begin : g_bit
            logic [STAGES-1:0] chain_q;

            // Shift the raw level through the synchronizer stages
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain_q <= {STAGES{RST_VAL}};
                end else begin
                    chain_q <= {chain_q[STAGES-2:0], async_i[b]};
                end
            end

            assign sync_o[b] = chain_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/occ_count.sv
// Module: occ_count
// Occupancy counter datapath, with full and empty flags for the controller.
// Assumes: the controller never asserts inc and dec together, and gates them
// with full and empty.
module occ_count #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    input  logic             dec_i,
    output logic [CNT_W-1:0] count_o,
    output logic             full_o,
    output logic             empty_o
);

    localparam logic [CNT_W-1:0] MAX_CNT = {CNT_W{1'b1}};

    logic [CNT_W-1:0] count_q;

    // Step the count by one on a strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (inc_i) begin
            count_q <= count_q + 1'b1;
        end else if (dec_i) begin
            count_q <= count_q - 1'b1;
        end
    end

    assign count_o = count_q;
    assign full_o  = (count_q == MAX_CNT);
    assign empty_o = (count_q == '0);

    // The count never wraps between its limits
    assert_no_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(($past(count_q) == MAX_CNT && count_q == '0) ||
          ($past(count_q) == '0 && count_q == MAX_CNT)));

    // Any change of count is a single step
    assert_single_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q != $past(count_q)) |->
            (count_q == $past(count_q) + 1'b1 || count_q == $past(count_q) - 1'b1));

endmodule

// File: rtl/occ_ctrl.sv
// Module: occ_ctrl
// Mealy controller that decodes the doorway beam order into
// increment/decrement strobes, and locks into an error state on illegal moves.
// Assumes: pos_i is already synchronized; only one person is in the doorway.
module occ_ctrl
    import occ_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] pos_i,
    input  logic       full_i,
    input  logic       empty_i,
    output logic       inc_o,
    output logic       dec_o,
    output logic       err_o
);

    state_t st_q, st_d;
    pos_t   pos;

    assign pos = pos_t'(pos_i);

    // Next state and Mealy strobes from the current state and doorway position
    always_comb begin
        st_d  = st_q;
        inc_o = 1'b0;
        dec_o = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                case (pos)
                    POS_OUT:  st_d = ST_ENT_OUT;
                    POS_IN:   st_d = ST_LVE_IN;
                    POS_BOTH: st_d = ST_ERR;
                    default:  st_d = ST_IDLE;
                endcase
            end
            ST_ENT_OUT: begin
                case (pos)
                    POS_CLEAR: st_d = ST_IDLE;
                    POS_BOTH:  st_d = ST_ENT_BOTH;
                    POS_IN:    st_d = ST_ERR;
                    default:   st_d = ST_ENT_OUT;
                endcase
            end
            ST_ENT_BOTH: begin
                case (pos)
                    POS_IN:    st_d = ST_ENT_IN;
                    POS_OUT:   st_d = ST_ENT_OUT;
                    POS_CLEAR: st_d = ST_ERR;
                    default:   st_d = ST_ENT_BOTH;
                endcase
            end
            ST_ENT_IN: begin
                case (pos)
                    POS_CLEAR: begin
                        if (full_i) begin
                            st_d = ST_ERR;
                        end else begin
                            st_d  = ST_IDLE;
                            inc_o = 1'b1;
                        end
                    end
                    POS_BOTH: st_d = ST_ENT_BOTH;
                    POS_OUT:  st_d = ST_ERR;
                    default:  st_d = ST_ENT_IN;
                endcase
            end
            ST_LVE_IN: begin
                case (pos)
                    POS_CLEAR: st_d = ST_IDLE;
                    POS_BOTH:  st_d = ST_LVE_BOTH;
                    POS_OUT:   st_d = ST_ERR;
                    default:   st_d = ST_LVE_IN;
                endcase
            end
            ST_LVE_BOTH: begin
                case (pos)
                    POS_OUT:   st_d = ST_LVE_OUT;
                    POS_IN:    st_d = ST_LVE_IN;
                    POS_CLEAR: st_d = ST_ERR;
                    default:   st_d = ST_LVE_BOTH;
                endcase
            end
            ST_LVE_OUT: begin
                case (pos)
                    POS_CLEAR: begin
                        if (empty_i) begin
                            st_d = ST_ERR;
                        end else begin
                            st_d  = ST_IDLE;
                            dec_o = 1'b1;
                        end
                    end
                    POS_BOTH: st_d = ST_LVE_BOTH;
                    POS_IN:   st_d = ST_ERR;
                    default:  st_d = ST_LVE_OUT;
                endcase
            end
            default: st_d = ST_ERR;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign err_o = (st_q == ST_ERR);

    // Strobes last exactly one cycle
    assert_strobe_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_o || dec_o) |=> !(inc_o || dec_o));

    // The error state is never left while out of reset
    assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_ERR) |=> (st_q == ST_ERR));

    // Both detector levels flipping at once leads to the error state
    assert_double_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && st_q != ST_ERR && (pos_i ^ $past(pos_i)) == 2'b11)
            |=> (st_q == ST_ERR));

    // No strobe at the count limits
    assert_guard_limits_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !((inc_o && full_i) || (dec_o && empty_i)));

endmodule

// File: rtl/occ_door_counter.sv
// Module: occ_door_counter
// Top of the doorway occupancy counter: synchronizers, controller, counter.
// Assumes: detector inputs are 1 when the beam is clear; one person at a time.
module occ_door_counter #(
    parameter int CNT_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             beam_out_i,
    input  logic             beam_in_i,
    output logic [CNT_W-1:0] count_o,
    output logic             error_o
);

    logic [1:0] beams_s;
    logic [1:0] pos;
    logic       inc, dec, full, empty;

    occ_sync #(
        .WIDTH  (2),
        .STAGES (SYNC_STAGES),
        .RST_VAL(1'b1)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i({beam_out_i, beam_in_i}),
        .sync_o (beams_s)
    );

    // Blocked flags: outside on bit1, inside on bit0
    assign pos = ~beams_s;

    occ_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .pos_i  (pos),
        .full_i (full),
        .empty_i(empty),
        .inc_o  (inc),
        .dec_o  (dec),
        .err_o  (error_o)
    );

    occ_count #(
        .CNT_W(CNT_W)
    ) u_count (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc_i  (inc),
        .dec_i  (dec),
        .count_o(count_o),
        .full_o (full),
        .empty_o(empty)
    );

    // Reset leaves an empty room with no error
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (count_o == '0 && !error_o));

    // A frozen count while in error
    assert_frozen_in_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(error_o)) |-> $stable(count_o));

endmodule

// File: tb/sim_occ_door_counter.sv
module sim_occ_door_counter;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       beam_out = 1'b1;
    logic       beam_in = 1'b1;
    logic [3:0] count;
    logic       error;

    int total = 0;
    int bad   = 0;
    int exp_cnt = 0;
    bit exp_err = 1'b0;
    bit done = 1'b0;

    typedef struct {
        int    cnt;
        bit    err;
        string tag;
    } exp_t;

    exp_t exp_q[$];

    always #4 clk = ~clk;

    occ_door_counter u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .beam_out_i(beam_out),
        .beam_in_i (beam_in),
        .count_o   (count),
        .error_o   (error)
    );

    // Monitor: pop each expected item and compare with the outputs
    initial begin
        forever begin
            exp_t it;
            wait (exp_q.size() != 0);
            it = exp_q.pop_front();
            total++;
            if (int'(count) != it.cnt || error != it.err) begin
                bad++;
                $display("FAIL %s: count=%0d error=%0d expected count=%0d error=%0d",
                         it.tag, count, error, it.cnt, it.err);
            end
        end
    end

    task automatic push(input string tag);
        exp_t it;
        it.cnt = exp_cnt;
        it.err = exp_err;
        it.tag = tag;
        exp_q.push_back(it);
        #1;
    endtask

    // Apply a position code {outside_blocked, inside_blocked} and hold it
    task automatic put(input logic [1:0] c, input int hold = 5);
        @(negedge clk);
        beam_out = ~c[1];
        beam_in  = ~c[0];
        repeat (hold - 1) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        beam_out = 1'b1;
        beam_in  = 1'b1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        exp_cnt = 0;
        exp_err = 1'b0;
        @(negedge clk);
    endtask

    task automatic enter();
        put(2'b10); put(2'b11); put(2'b01); put(2'b00);
        if (!exp_err) begin
            if (exp_cnt == 15) exp_err = 1'b1;
            else exp_cnt++;
        end
    endtask

    task automatic leave();
        put(2'b01); put(2'b11); put(2'b10); put(2'b00);
        if (!exp_err) begin
            if (exp_cnt == 0) exp_err = 1'b1;
            else exp_cnt--;
        end
    endtask

    // Driver
    initial begin
        do_reset();
        push("R1 reset state");

        enter(); push("R2 first entry");
        enter(); enter(); push("R2 three entries");
        leave(); push("R3 exit");

        put(2'b10); put(2'b00); push("R4 turn back from outside");
        put(2'b10); put(2'b11); put(2'b10); put(2'b00); push("R4 turn back from doorway");
        put(2'b10); put(2'b11); put(2'b01); put(2'b11); put(2'b10); put(2'b00);
        push("R4 turn back from inside");
        put(2'b01); put(2'b11); put(2'b01); put(2'b00); push("R4 exit turn back");
        put(2'b10); put(2'b11); put(2'b10); put(2'b11); put(2'b01); put(2'b00);
        exp_cnt++; push("R4 double reversal then entry");

        // R8 latency: count changes on the third edge after the final clear
        put(2'b10); put(2'b11); put(2'b01);
        @(negedge clk); beam_out = 1'b1; beam_in = 1'b1;
        @(negedge clk); push("R8 unchanged after one edge");
        @(negedge clk); push("R8 unchanged after two edges");
        @(negedge clk); exp_cnt++; push("R8 step on third edge");
        repeat (2) @(negedge clk); push("R8 single step only");

        while (exp_cnt < 15) enter();
        push("R2 room full");
        enter(); push("R7 entry at capacity");
        leave(); push("R6 exit ignored in error");
        put(2'b11); put(2'b00); push("R6 jumps ignored in error");

        do_reset(); push("R6 reset clears error");
        leave(); push("R7 exit at empty");

        do_reset(); enter();
        put(2'b11); exp_err = 1'b1; push("R5 clear to both");
        do_reset();
        put(2'b10); put(2'b01); exp_err = 1'b1; push("R5 outside to inside");
        do_reset();
        put(2'b01); put(2'b10); exp_err = 1'b1; push("R5 inside to outside");
        do_reset();
        put(2'b10); put(2'b11); put(2'b00); exp_err = 1'b1; push("R5 both to clear");

        wait (exp_q.size() == 0);
        #1;
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule